// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN message should be taken in, by looking at the upper eight bits of its 11-bit identifier. It holds a programmable acceptance code and a programmable mask. Each mask bit picks whether the identifier bit at the same position has to equal the code bit (mask bit 0) or is left out of the decision (mask bit 1). The frame receiver presents the identifier with a one-cycle strobe. The block then answers with a one-cycle, registered accept or reject result.

Software programs the code and the mask through a small register port with address, write data, write enable and read data. Both registers can only be reached while the controller is held in reset-request mode. At any other time, writes have no effect and reads return zero. This keeps the filter from being changed in the middle of live traffic.

Top module: `idacc_filter`

## Requirements
- R1: The code register is at address 0x24 and the mask register is at address 0x25. Each is 8 bits wide. When reg_we is high and reset_req is high, the addressed register takes reg_wdata at the clock edge. From the cycle after that edge, reg_rdata shows the new value while the same address is selected.
- R2: While reset_req is low, a write to 0x24 or 0x25 leaves both registers unchanged, and reg_rdata reads 0x00 whatever the address.
- R3: Only id_bits[10:3] take part in the comparison. Mask and code bit i pair with identifier bit i+3. id_bits[2:0] never change the result.
- R4: res_accept is 1 when, for every position i whose mask bit is 0, id_bits[i+3] equals code bit i. It is 0 when any such position differs.
- R5: With the mask set to 0xFF, every identifier is accepted, whatever the code.
- R6: res_valid is high for exactly the one cycle that follows a cycle with id_valid high. res_accept is 0 whenever res_valid is 0.
- R7: After reset, res_valid and res_accept are 0, and both registers read 0x00.
- R8: While reset_req is high, reads of any address other than 0x24 and 0x25 return 0x00. Writes to those other addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_req | input | 1 | Controller reset-request state; 1 unlocks the filter registers |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data (combinational from the address) |
| id_valid | input | 1 | Strobe: id_bits holds a received identifier |
| id_bits | input | 11 | Received 11-bit identifier |
| res_valid | output | 1 | Result strobe, one cycle after id_valid |
| res_accept | output | 1 | 1 = identifier accepted; qualified by res_valid |

## Verification
A register write becomes visible on reg_rdata after the single clock edge that captures it. The bench drives each write on a falling edge and reads back on the next falling edge. The filter result goes through one register, so it is due one edge after the strobe. The bench raises id_valid on a falling edge and samples res_valid and res_accept on the falling edge that follows. It then drops the strobe and checks one falling edge later that the result has gone low again. The bench never changes the filter registers in the same cycle as a strobe, so every expected result depends only on the code and mask already settled.

// File: rtl/idacc_pkg.sv
package idacc_pkg;
  localparam int unsigned ID_W   = 11;
  localparam int unsigned FLT_W  = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned LSB_OFS = ID_W - FLT_W;
  localparam logic [ADDR_W-1:0] CODE_ADDR = 8'h24;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h25;

  typedef enum logic [1:0] {SEL_NONE, SEL_CODE, SEL_MASK} reg_sel_e;

  // Upper identifier bits that take part in filtering
  function automatic logic [FLT_W-1:0] id_upper(input logic [ID_W-1:0] id);
    return id[ID_W-1 -: FLT_W];
  endfunction

  // Accept when every cared position (mask bit 0) agrees with the code
  function automatic logic filt_accept(input logic [FLT_W-1:0] idu,
                                       input logic [FLT_W-1:0] code,
                                       input logic [FLT_W-1:0] mask);
    return &(mask | ~(idu ^ code));
  endfunction

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a == CODE_ADDR) return SEL_CODE;
    if (a == MASK_ADDR) return SEL_MASK;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/idacc_regs.sv
module idacc_regs
  import idacc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = FLT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlock,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] code_q,
  output logic [DW-1:0] mask_q,
  output logic          wr_code,
  output logic          wr_mask
);
  reg_sel_e sel;

  always_comb sel = decode_addr(addr);

  assign wr_code = unlock && we && (sel == SEL_CODE);
  assign wr_mask = unlock && we && (sel == SEL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_code) code_q <= wdata;
      if (wr_mask) mask_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (unlock) begin
      unique case (sel)
        SEL_CODE: rdata = code_q;
        SEL_MASK: rdata = mask_q;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/idacc_match.sv
module idacc_match
  import idacc_pkg::*;
#(
  parameter int unsigned W = FLT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] idu,
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  output logic [W-1:0] bit_hit,
  output logic         hit_now,
  output logic         out_valid,
  output logic         out_accept
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_hit[i] = mask[i] | (idu[i] ~^ code[i]);
  end

  assign hit_now = &bit_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else begin
      out_valid  <= strobe;
      out_accept <= strobe & hit_now;
    end
  end
endmodule

// File: rtl/idacc_filter.sv
module idacc_filter
  import idacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [FLT_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [FLT_W-1:0]  reg_rdata,
  input  logic              id_valid,
  input  logic [ID_W-1:0]   id_bits,
  output logic              res_valid,
  output logic              res_accept
);
  logic [FLT_W-1:0] code_q, mask_q, id_hi, bit_hit;
  logic             wr_code, wr_mask, hit_now;

  assign id_hi = id_upper(id_bits);

  idacc_regs #(.AW(ADDR_W), .DW(FLT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlock(reset_req),
    .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .code_q(code_q), .mask_q(mask_q),
    .wr_code(wr_code), .wr_mask(wr_mask)
  );

  idacc_match #(.W(FLT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .strobe(id_valid), .idu(id_hi),
    .code(code_q), .mask(mask_q), .bit_hit(bit_hit), .hit_now(hit_now),
    .out_valid(res_valid), .out_accept(res_accept)
  );
endmodule

// File: rtl/idacc_filter_chk.sv
module idacc_filter_chk
  import idacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reset_req,
  input logic [FLT_W-1:0]  reg_wdata,
  input logic [FLT_W-1:0]  reg_rdata,
  input logic              id_valid,
  input logic [ID_W-1:0]   id_bits,
  input logic              res_valid,
  input logic              res_accept,
  input logic [FLT_W-1:0]  code_q,
  input logic [FLT_W-1:0]  mask_q,
  input logic              wr_code,
  input logic              wr_mask
);
  assert_code_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_code |=> code_q == $past(reg_wdata));
  assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(reg_wdata));
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_req |=> $stable(code_q) && $stable(mask_q));
  assert_locked_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_req |-> reg_rdata == '0);
  assert_accept_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_accept == $past(filt_accept(id_upper(id_bits), code_q, mask_q)));
  assert_open_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && mask_q == '1) |=> res_accept);
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid);
  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid);
  assert_accept_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_accept);
endmodule

bind idacc_filter idacc_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .id_valid(id_valid), .id_bits(id_bits),
  .res_valid(res_valid), .res_accept(res_accept), .code_q(code_q),
  .mask_q(mask_q), .wr_code(wr_code), .wr_mask(wr_mask)
);

// File: tb/tb_idacc_filter.sv
module tb_idacc_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        id_valid = 1'b0;
  logic [10:0] id_bits = '0;
  logic        res_valid, res_accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] m_code = 8'h00;
  logic [7:0] m_mask = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  idacc_filter dut (.*);

  // Bench model: bit-by-bit walk over identifier bits 10..3
  function automatic logic model_accept(logic [10:0] id, logic [7:0] c, logic [7:0] m);
    for (int b = 0; b < 8; b++)
      if (m[b] == 1'b0 && id[b+3] != c[b]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (reset_req) begin
      if (a == 8'h24) m_code = d;
      if (a == 8'h25) m_mask = d;
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic strobe(string req, logic [10:0] id);
    id_bits = id; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    check({req, " valid"}, {7'b0, res_valid}, 8'h01);
    check({req, " accept"}, {7'b0, res_accept}, {7'b0, model_accept(id, m_code, m_mask)});
    @(negedge clk);
    check("R6 drop", {6'b0, res_valid, res_accept}, 8'h00);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 res_valid", {7'b0, res_valid}, 8'h00);
    check("R7 res_accept", {7'b0, res_accept}, 8'h00);
    reset_req = 1'b1;
    rd("R7 code", 8'h24, 8'h00);
    rd("R7 mask", 8'h25, 8'h00);
    // R1 write and read back
    wr(8'h24, 8'hA5); rd("R1 code", 8'h24, 8'hA5);
    wr(8'h25, 8'h3C); rd("R1 mask", 8'h25, 8'h3C);
    // R8 other addresses
    wr(8'h26, 8'hFF); rd("R8 read 26", 8'h26, 8'h00);
    rd("R8 code kept", 8'h24, 8'hA5);
    rd("R8 mask kept", 8'h25, 8'h3C);
    // R2 locked access
    reset_req = 1'b0;
    wr(8'h24, 8'h11); wr(8'h25, 8'h22);
    rd("R2 locked read code", 8'h24, 8'h00);
    rd("R2 locked read mask", 8'h25, 8'h00);
    reset_req = 1'b1;
    rd("R2 code unchanged", 8'h24, 8'hA5);
    rd("R2 mask unchanged", 8'h25, 8'h3C);
    // R4 exact match, mask 0
    wr(8'h25, 8'h00);
    strobe("R4 exact", {8'hA5, 3'b000});
    strobe("R4 one-bit miss", {8'hA4, 3'b000});
    // R3 low bits ignored
    strobe("R3 low bits 111", {8'hA5, 3'b111});
    strobe("R3 low bits 101 miss", {8'h25, 3'b101});
    // R5 open mask
    wr(8'h25, 8'hFF);
    strobe("R5 open", 11'h000);
    strobe("R5 open2", 11'h7FF);
    // R4 partial mask
    wr(8'h25, 8'hF0);
    strobe("R4 partial hit", {4'h3, 4'h5, 3'b010});
    strobe("R4 partial miss", {4'h3, 4'h4, 3'b010});
    // R4 random mix, filter changed only while unlocked
    for (int k = 0; k < 300; k++) begin
      if (k % 10 == 0) begin
        reset_req = 1'b1;
        wr(8'h24, 8'($urandom));
        case ($urandom % 4)
          0: wr(8'h25, 8'hFF);
          1: wr(8'h25, 8'h00);
          default: wr(8'h25, 8'($urandom));
        endcase
        reset_req = 1'($urandom);
      end
      if ($urandom % 3 == 0)
        strobe("R4 random near", {m_code ^ (8'h1 << ($urandom % 8)), 3'($urandom)});
      else if ($urandom % 2 == 0)
        strobe("R4 random hit", {m_code, 3'($urandom)});
      else
        strobe("R4 random", 11'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule